// File: doc/BRIEF.md
# Code Fetch Source Selector

This block sits beside the instruction fetch unit and decides, for each requested code byte, whether it is read from the 16 KB on-chip program store or from the external program bus. It takes the fetch address, the external-access strap pin and a 3-bit protection setting. It returns a registered select plus the address to present to whichever memory was chosen. Addresses above the last on-chip byte always go to the external bus. Below that boundary, an unprotected part obeys the live strap pin. A protected part always reads on-chip memory there.

When any protection level is active, the strap pin is captured while reset is held. From then on the selector reports that captured level rather than the live pin. All results appear on the clock edge after the request, so the select and both addresses stay aligned with each other. The address of the memory that was not chosen keeps its previous value, which avoids needless toggling on that bus.

Top module: `fetch_src_sel`

## Requirements
- R1: `fetch_vld` is 1 in the cycle after a clock edge that sampled `fetch_req` high, and 0 after an edge that sampled it low.
- R2: A request with `pc` above 0x3FFF yields `sel_ext` = 1 (1 means external, 0 means on-chip) under every `prot_mode` value and either pin level.
- R3: With `prot_mode` = 0 (unprotected), a request with `pc` at or below 0x3FFF yields `sel_ext` = 0 when `ext_pin` is 1 at that edge, and `sel_ext` = 1 when it is 0.
- R4: With `prot_mode` = 1, 2 or 4 (level 1, level 2, ROM-protected), a request with `pc` at or below 0x3FFF yields `sel_ext` = 0 whatever the live or captured pin level.
- R5: With `prot_mode` = 3 (level 3), a request with `pc` at or below 0x3FFF yields `sel_ext` = 0, including the first fetch after reset, whatever the pin level.
- R6: `pin_seen` shows the strap level used for a request: the live `ext_pin` when `prot_mode` = 0, otherwise the value `ext_pin` had at the last clock edge with `rst_n` low.
- R7: The unused codes 5, 6 and 7 of `prot_mode` behave exactly like code 4 (ROM-protected).
- R8: After a request, `int_addr` equals `pc[13:0]` if on-chip was selected, and `ext_addr` equals `pc` if external was selected. The address of the memory that was not selected keeps its previous value.
- R9: After an edge with no request, `sel_ext`, `pin_seen`, `int_addr` and `ext_addr` keep their values.
- R10: Reset is synchronous and active-low. After any edge with `rst_n` low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; strap pin is captured while low |
| fetch_req | input | 1 | A code fetch is requested at `pc` this cycle |
| pc | input | 16 | Fetch address |
| ext_pin | input | 1 | External-access strap pin, 1 allows on-chip fetches |
| prot_mode | input | 3 | 0 open, 1..3 level 1..3, 4 ROM-protected, 5..7 as 4 |
| fetch_vld | output | 1 | Registered request strobe aligned with the outputs below |
| sel_ext | output | 1 | 1 = fetch from external bus, 0 = on-chip |
| pin_seen | output | 1 | Strap level that governed the decision |
| int_addr | output | 14 | Address to the on-chip program store |
| ext_addr | output | 16 | Address to the external program bus |

## Verification
Every output is due exactly one clock edge after the inputs that produced it. The strap capture reflects the pin at the final low-reset edge and takes effect from the first fetch after release. The bench drives inputs on the falling edge. On each rising edge, its reference model pushes the expected output state into a queue. On the next falling edge, the queue entry is popped and compared with the ports, so no check looks at a value before its register has loaded. For every mode code and both captured pin levels, directed sequences hit 0x3FFF and 0x4000 with the live pin at each level. A long randomized run with occasional resets follows.

// File: rtl/fss_pkg.sv
// Shared definitions for the fetch source selector.
// Assumes protection codes above the ROM-protected code are treated as it.
package fss_pkg;

    // Protection setting codes as presented on prot_mode.
    typedef enum logic [2:0] {
        PM_OPEN = 3'd0,
        PM_LVL1 = 3'd1,
        PM_LVL2 = 3'd2,
        PM_LVL3 = 3'd3,
        PM_ROM  = 3'd4
    } prot_mode_e;

    // Decision made for one fetch before it is registered.
    typedef struct packed {
        logic go_ext;
        logic pin_used;
    } route_t;

    // True when any protection is active (every code other than open).
    function automatic logic is_protected(input logic [2:0] mode);
        return (mode != PM_OPEN);
    endfunction

endpackage

// File: rtl/fss_pin_hold.sv
// Strap capture: follows the external-access pin on every clock edge while
// reset is held. After release it keeps the value seen at the last reset edge.
// Assumes rst_n is synchronous to clk.
module fss_pin_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_pin,
    output logic held_pin
);

    // Sample the strap only during reset; hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_pin <= ext_pin;
        end
    end

endmodule

// File: rtl/fss_route.sv
// Combinational fetch routing. Compares the address against the last on-chip
// byte and applies the protection rules to pick on-chip or external storage.
// Assumes held_pin comes from the reset-time capture.
module fss_route
    import fss_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] ONCHIP_LAST = 16'h3FFF
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [2:0]        prot_mode,
    input  logic              live_pin,
    input  logic              held_pin,
    output route_t            route
);

    logic above_onchip;
    logic prot_on;

    // Classify the address and the protection state.
    always_comb begin
        above_onchip = (pc > ONCHIP_LAST);
        prot_on      = is_protected(prot_mode);
    end

    // Pick the source: high addresses are external, low ones follow the rules.
    always_comb begin
        route.pin_used = prot_on ? held_pin : live_pin;
        if (above_onchip) begin
            route.go_ext = 1'b1;
        end else if (prot_on) begin
            route.go_ext = 1'b0;
        end else begin
            route.go_ext = ~live_pin;
        end
    end

endmodule

// File: rtl/fss_out_reg.sv
// Output stage: registers the routing decision and steers the fetch address
// to the chosen memory. The address of the memory not chosen keeps its value.
// Assumes synchronous active-low reset.
module fss_out_reg
    import fss_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int INT_AW = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] pc,
    input  route_t            route,
    output logic              fetch_vld,
    output logic              sel_ext,
    output logic              pin_seen,
    output logic [INT_AW-1:0] int_addr,
    output logic [ADDR_W-1:0] ext_addr
);

    // Request strobe, one cycle behind the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_vld <= 1'b0;
        end else begin
            fetch_vld <= fetch_req;
        end
    end

    // Select and strap report, loaded only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_ext  <= 1'b0;
            pin_seen <= 1'b0;
        end else if (fetch_req) begin
            sel_ext  <= route.go_ext;
            pin_seen <= route.pin_used;
        end
    end

    // On-chip address, loaded only when the on-chip store is chosen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_addr <= '0;
        end else if (fetch_req && !route.go_ext) begin
            int_addr <= pc[INT_AW-1:0];
        end
    end

    // External address, loaded only when the external bus is chosen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_addr <= '0;
        end else if (fetch_req && route.go_ext) begin
            ext_addr <= pc;
        end
    end

endmodule

// File: rtl/fetch_src_sel.sv
// Top of the fetch source selector. Captures the strap at reset, routes each
// fetch, and registers the result with the steered addresses.
// Assumes on-chip size is a power of two not larger than the code space.
module fetch_src_sel
    import fss_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int ONCHIP_BYTES = 16384
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            fetch_req,
    input  logic [ADDR_W-1:0]               pc,
    input  logic                            ext_pin,
    input  logic [2:0]                      prot_mode,
    output logic                            fetch_vld,
    output logic                            sel_ext,
    output logic                            pin_seen,
    output logic [$clog2(ONCHIP_BYTES)-1:0] int_addr,
    output logic [ADDR_W-1:0]               ext_addr
);

    localparam int                INT_AW      = $clog2(ONCHIP_BYTES);
    localparam logic [ADDR_W-1:0] ONCHIP_LAST = ADDR_W'(ONCHIP_BYTES - 1);

    logic   held_pin;
    route_t route;

    fss_pin_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_pin  (ext_pin),
        .held_pin (held_pin)
    );

    fss_route #(
        .ADDR_W      (ADDR_W),
        .ONCHIP_LAST (ONCHIP_LAST)
    ) u_route (
        .pc        (pc),
        .prot_mode (prot_mode),
        .live_pin  (ext_pin),
        .held_pin  (held_pin),
        .route     (route)
    );

    fss_out_reg #(
        .ADDR_W (ADDR_W),
        .INT_AW (INT_AW)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_req (fetch_req),
        .pc        (pc),
        .route     (route),
        .fetch_vld (fetch_vld),
        .sel_ext   (sel_ext),
        .pin_seen  (pin_seen),
        .int_addr  (int_addr),
        .ext_addr  (ext_addr)
    );

endmodule

// File: rtl/fss_chk.sv
// Property checker for the fetch source selector, bound to the top module.
// Watches only the top-level ports.
module fss_chk #(
    parameter int ADDR_W = 16,
    parameter int INT_AW = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] pc,
    input logic              ext_pin,
    input logic [2:0]        prot_mode,
    input logic              fetch_vld,
    input logic              sel_ext,
    input logic [INT_AW-1:0] int_addr,
    input logic [ADDR_W-1:0] ext_addr
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'((1 << INT_AW) - 1);

    // R1
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> fetch_vld);

    // R2
    high_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && pc > LAST) |=> sel_ext);

    // R4 R5 R7
    prot_low_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && prot_mode != 3'd0 && pc <= LAST) |=> !sel_ext);

    // R3
    open_low_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && prot_mode == 3'd0 && pc <= LAST) |=> (sel_ext == !$past(ext_pin)));

    // R8
    addr_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> (sel_ext ? (ext_addr == $past(pc)) : (int_addr == $past(pc[INT_AW-1:0]))));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req |=> ($stable(sel_ext) && $stable(int_addr) && $stable(ext_addr) && !fetch_vld));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!fetch_vld && !sel_ext && int_addr == '0 && ext_addr == '0));

endmodule

bind fetch_src_sel fss_chk #(
    .ADDR_W (ADDR_W),
    .INT_AW ($clog2(ONCHIP_BYTES))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_req (fetch_req),
    .pc        (pc),
    .ext_pin   (ext_pin),
    .prot_mode (prot_mode),
    .fetch_vld (fetch_vld),
    .sel_ext   (sel_ext),
    .int_addr  (int_addr),
    .ext_addr  (ext_addr)
);

// File: tb/fetch_src_sel_tb.sv
`timescale 1ns/1ps
// Bench for the fetch source selector: behavioural reference model with a
// queue of expected output states, compared on every falling edge.
module fetch_src_sel_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [15:0] pc = 16'h0;
    logic        ext_pin = 1'b1;
    logic [2:0]  prot_mode = 3'd0;
    logic        fetch_vld, sel_ext, pin_seen;
    logic [13:0] int_addr;
    logic [15:0] ext_addr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fetch_src_sel u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_req (fetch_req),
        .pc        (pc),
        .ext_pin   (ext_pin),
        .prot_mode (prot_mode),
        .fetch_vld (fetch_vld),
        .sel_ext   (sel_ext),
        .pin_seen  (pin_seen),
        .int_addr  (int_addr),
        .ext_addr  (ext_addr)
    );

    typedef struct {
        bit        vld;
        bit        sel;
        bit        pin;
        bit [13:0] ia;
        bit [15:0] ea;
        string     t_sel;
        string     t_pin;
        string     t_addr;
        string     t_vld;
    } exp_t;

    exp_t q[$];
    exp_t m;
    bit   m_held = 1'b0;

    // Reference model: compute the state due after this rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_held = ext_pin;
            m.vld = 0; m.sel = 0; m.pin = 0; m.ia = '0; m.ea = '0;
            m.t_sel = "R10"; m.t_pin = "R10"; m.t_addr = "R10"; m.t_vld = "R10";
        end else if (fetch_req) begin
            m.vld = 1; m.t_vld = "R1";
            if (pc >= 16'h4000) begin
                m.sel = 1; m.t_sel = "R2";
            end else if (prot_mode == 3'd0) begin
                m.sel = !ext_pin; m.t_sel = "R3";
            end else begin
                m.sel = 0;
                m.t_sel = (prot_mode == 3'd3) ? "R5" : (prot_mode >= 3'd5) ? "R7" : "R4";
            end
            m.pin = (prot_mode == 3'd0) ? ext_pin : m_held;
            m.t_pin = "R6";
            if (m.sel) m.ea = pc; else m.ia = pc[13:0];
            m.t_addr = "R8";
        end else begin
            m.vld = 0; m.t_vld = "R1";
            m.t_sel = "R9"; m.t_pin = "R9"; m.t_addr = "R9";
        end
        q.push_back(m);
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare the ports with the oldest expected state, away from the edge.
    always @(negedge clk) begin
        if (!done && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.t_vld,  "fetch_vld", int'(fetch_vld), int'(e.vld));
            chk(e.t_sel,  "sel_ext",   int'(sel_ext),   int'(e.sel));
            chk(e.t_pin,  "pin_seen",  int'(pin_seen),  int'(e.pin));
            chk(e.t_addr, "int_addr",  int'(int_addr),  int'(e.ia));
            chk(e.t_addr, "ext_addr",  int'(ext_addr),  int'(e.ea));
        end
    end

    task automatic step(input bit req, input logic [15:0] a, input bit pin, input logic [2:0] md);
        @(negedge clk);
        fetch_req = req; pc = a; ext_pin = pin; prot_mode = md;
    endtask

    task automatic do_reset(input bit pin, input logic [2:0] md, input int n);
        @(negedge clk);
        rst_n = 1'b0; fetch_req = 1'b0; ext_pin = pin; prot_mode = md;
        repeat (n) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_all();
        // R10: reset state with the first reset held a few cycles
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int md = 0; md < 8; md++) begin
            for (int hp = 0; hp < 2; hp++) begin
                do_reset(bit'(hp), 3'(md), 2);
                // R5: first fetch after reset at address zero
                step(1, 16'h0000, !bit'(hp), 3'(md));
                // R2 R3 R4 R7: both sides of the on-chip boundary, pin high and low
                step(1, 16'h3FFF, 1, 3'(md));
                step(1, 16'h4000, 1, 3'(md));
                step(1, 16'h3FFF, 0, 3'(md));
                step(1, 16'h4000, 0, 3'(md));
                // R9: idle cycles hold state
                step(0, 16'h1234, 1, 3'(md));
                step(0, 16'h9876, 0, 3'(md));
                step(1, 16'hFFFF, 1, 3'(md));
                step(1, 16'h2AAA, 0, 3'(md));
            end
        end
        // Randomized sweep with occasional resets (R6 capture under live toggling)
        for (int i = 0; i < 2000; i++) begin
            if ((i % 97) == 0)
                do_reset(bit'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), 1);
            step(bit'($urandom_range(0, 3) != 0),
                 ($urandom_range(0, 3) == 0) ? (16'h3FFE + 16'($urandom_range(0, 3)))
                                              : 16'($urandom_range(0, 16'hFFFF)),
                 bit'($urandom_range(0, 1)), prot_mode);
        end
        step(0, 16'h0, 1, 3'd0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                bad++; total++;
                $display("FAIL watchdog expired");
            end
        join_any
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule